// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the low-order address bits for a four-beat burst into a synchronous memory. At the start of a burst, a load strobe captures a starting address. That value is driven out in the same cycle as the first beat. Each later clock that has advance asserted moves the burst to its next beat. A static ordering input chooses one of two beat orders. In the wrapping linear order, the address steps up by one modulo the burst length. In the interleaved order, the address for beat n is the start address XOR n. From the same start value, the two orders give different sequences.

A standby input puts the block to sleep. While it is high, advance and load are both ignored and the address output holds its value. An external tie-low on standby keeps the block active. A last-beat flag marks the final beat of the burst so that the surrounding controller can close or restart the burst. After the fourth beat, a further advance returns the sequence to the start address.

Top module: `bseq_gen`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the beat index and the captured start are cleared. After reset, `addr_o` reads 0 and `last_o` reads 0.
- R2: When `load_i`=1 and `sleep_i`=0, `addr_o` equals `start_i` in that same cycle. After the edge, that value is presented as beat 0 of a new burst.
- R3: With `ilv_i`=0 (linear), beat n of a burst presents (start + n) mod 4, for all four start values.
- R4: With `ilv_i`=1 (interleaved), beat n of a burst presents start XOR n, for all four start values.
- R5: After the beat with index 3, one more advance returns the burst to beat 0, which presents the start address again.
- R6: `last_o` is 1 exactly when the presented beat index is 3. A beat being loaded has index 0.
- R7: An edge with `adv_i`=0 and no accepted load leaves `addr_o` and `last_o` unchanged.
- R8: While `sleep_i`=1, `adv_i` and `load_i` have no effect. `addr_o` keeps its value, both in the same cycle and after the edge.
- R9: When `load_i` and `adv_i` are both 1, the load wins. The next cycle presents beat 0 of the new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Start a new burst from `start_i` |
| start_i | input | AW | Starting low address bits |
| adv_i | input | 1 | Step to the next beat |
| ilv_i | input | 1 | Ordering: 0 linear, 1 interleaved |
| sleep_i | input | 1 | Standby, freezes the block; tie low for active |
| addr_o | output | AW | Current burst address bits |
| last_o | output | 1 | Presented beat is the final one |

## Verification
The bench runs every start value in both orderings through five advances. A design that confused the two orders, or that carried into the upper bit in interleaved mode, gives wrong middle beats. A design that failed to wrap would present a fifth address other than the start. The bench also checks the same-cycle load bypass, which a fully registered design would miss by one cycle. It checks that a load beats an advance; getting this wrong would leave the burst at beat 1. Finally, it checks that a load or advance is refused during standby. A design that gated only the advance would jump to the new start.

// File: rtl/bseq_pkg.sv
// Package: shared types for the burst sequence generator.
// Assumes: the ordering mode is a single static select bit.
package bseq_pkg;
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/bseq_beat_ctr.sv
// Module: holds the captured start address and the beat index of the burst.
// Assumes: load_acc and step are mutually exclusive (the top gives load priority).
module bseq_beat_ctr #(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_acc,
    input  logic          step,
    input  logic [AW-1:0] start_d,
    output logic [AW-1:0] start_q,
    output logic [AW-1:0] beat_q
);
    // Capture the start on load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        start_q <= '0;
        else if (load_acc) start_q <= start_d;
    end

    // Beat index: reset or load to zero, step wraps naturally modulo 2**AW.
    always_ff @(posedge clk) begin
        if (!rst_n)        beat_q <= '0;
        else if (load_acc) beat_q <= '0;
        else if (step)     beat_q <= beat_q + 1'b1;
    end
endmodule

// File: rtl/bseq_order_map.sv
// Module: maps (start, beat index, ordering) onto the presented address.
// Assumes: pure combinational; the ordering select may change at any time.
module bseq_order_map #(
    parameter int AW = 2
) (
    input  logic             [AW-1:0] start,
    input  logic             [AW-1:0] beat,
    input  bseq_pkg::order_e          order,
    output logic             [AW-1:0] addr
);
    logic [AW-1:0] lin_addr;
    logic [AW-1:0] xor_addr;

    // Linear order: modular sum, carry out is dropped.
    assign lin_addr = start + beat;

    // Interleaved order: bitwise toggle, one generate slice per address bit.
    for (genvar b = 0; b < AW; b++) begin : g_xor
        assign xor_addr[b] = start[b] ^ beat[b];
    end

    // Select the ordering.
    always_comb begin
        addr = (order == bseq_pkg::ORD_XOR) ? xor_addr : lin_addr;
    end
endmodule

// File: rtl/bseq_gen.sv
// Module: top of the burst address sequence generator.
// Assumes: sleep_i is held low by the system when unused; rst_n is synchronous, active low.
module bseq_gen #(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] start_i,
    input  logic          adv_i,
    input  logic          ilv_i,
    input  logic          sleep_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);
    localparam logic [AW-1:0] LAST_BEAT = {AW{1'b1}};

    logic             load_acc;
    logic             step;
    logic [AW-1:0]    start_q;
    logic [AW-1:0]    beat_q;
    logic [AW-1:0]    start_eff;
    logic [AW-1:0]    beat_eff;
    bseq_pkg::order_e order;

    // Qualify the strobes: standby blocks both, load outranks advance.
    always_comb begin
        load_acc = load_i & ~sleep_i;
        step     = adv_i & ~sleep_i & ~load_i;
        order    = bseq_pkg::order_e'(ilv_i);
    end

    bseq_beat_ctr #(.AW(AW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_acc (load_acc),
        .step     (step),
        .start_d  (start_i),
        .start_q  (start_q),
        .beat_q   (beat_q)
    );

    // Bypass a loading start so beat 0 appears in the load cycle.
    always_comb begin
        start_eff = load_acc ? start_i : start_q;
        beat_eff  = load_acc ? '0      : beat_q;
    end

    bseq_order_map #(.AW(AW)) u_map (
        .start (start_eff),
        .beat  (beat_eff),
        .order (order),
        .addr  (addr_o)
    );

    // Final beat flag on the presented index.
    assign last_o = (beat_eff == LAST_BEAT);
endmodule

// File: rtl/bseq_gen_chk.sv
// Module: property checker for bseq_gen, attached by bind below.
// Assumes: observes ports only; keeps its own beat count from the strobes.
module bseq_gen_chk #(
    parameter int AW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_i,
    input logic [AW-1:0] start_i,
    input logic          adv_i,
    input logic          ilv_i,
    input logic          sleep_i,
    input logic [AW-1:0] addr_o,
    input logic          last_o
);
    logic          past_ok;
    logic          in_rst_q;
    logic [AW-1:0] cnt_q;
    logic          ld;
    logic          st;
    logic [AW-1:0] eff;
    logic [AW-1:0] flip;

    assign ld   = load_i & ~sleep_i;
    assign st   = adv_i & ~sleep_i & ~load_i;
    assign eff  = ld ? '0 : cnt_q;
    assign flip = eff ^ (eff + 1'b1);

    // Track whether the previous edge was out of reset.
    always_ff @(posedge clk) begin
        past_ok  <= rst_n;
        in_rst_q <= ~rst_n;
    end

    // Independent beat count derived from the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt_q <= '0;
        else if (ld) cnt_q <= '0;
        else if (st) cnt_q <= cnt_q + 1'b1;
    end

    // R1
    always_ff @(negedge clk) begin
        if (in_rst_q && rst_n && !ld)
            rst_clear_chk: assert (addr_o == '0 && !last_o);
    end

    // R2
    load_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> addr_o == start_i);

    // R7 R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(!st && !ld) && !ld && ilv_i == $past(ilv_i)) |-> $stable(addr_o));

    // R3
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(st) && !ld && !ilv_i && !$past(ilv_i)) |-> addr_o == $past(addr_o) + 1'b1);

    // R4
    xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(st) && !ld && ilv_i && $past(ilv_i)) |-> (addr_o ^ $past(addr_o)) == $past(flip));

    // R6
    last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o == (eff == {AW{1'b1}}));
endmodule

bind bseq_gen bseq_gen_chk #(.AW(AW)) u_bseq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .start_i (start_i),
    .adv_i   (adv_i),
    .ilv_i   (ilv_i),
    .sleep_i (sleep_i),
    .addr_o  (addr_o),
    .last_o  (last_o)
);

// File: tb/bseq_gen_bench.sv
// Bench: sweeps all start values in both orders, then the control corners.
module bseq_gen_bench;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [AW-1:0] start_i = '0;
    logic          adv_i = 1'b0;
    logic          ilv_i = 1'b0;
    logic          sleep_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic          last_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bseq_gen #(.AW(AW)) u_bseq_gen (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
        .adv_i(adv_i), .ilv_i(ilv_i), .sleep_i(sleep_i),
        .addr_o(addr_o), .last_o(last_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_addr(input int s, input int n, input bit ilv);
        return ilv ? ((s ^ n) & 3) : ((s + n) % 4);
    endfunction

    task automatic edge_then_settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        edge_then_settle();
        edge_then_settle();
        rst_n = 1'b1;
        #1;
        chk("R1 addr", int'(addr_o), 0);
        chk("R1 last", int'(last_o), 0);

        // R3 R4 R5 R6 sweep: every start, both orders, five advances
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                ilv_i = m[0];
                load_i = 1'b1; start_i = s[AW-1:0]; adv_i = 1'b0;
                #1;
                chk("R2 bypass", int'(addr_o), s);
                chk("R6 load last", int'(last_o), 0);
                edge_then_settle();
                load_i = 1'b0; adv_i = 1'b1;
                for (int n = 0; n < 5; n++) begin
                    #1;
                    chk(m ? "R4 xor beat" : "R3 lin beat", int'(addr_o), expect_addr(s, n % 4, m[0]));
                    chk("R6 last", int'(last_o), (n % 4 == 3) ? 1 : 0);
                    if (n == 4) chk("R5 wrap", int'(addr_o), s);
                    edge_then_settle();
                end
            end
        end

        // R7 hold with advance low
        ilv_i = 1'b0;
        load_i = 1'b1; start_i = 2'd1; adv_i = 1'b0;
        edge_then_settle();
        load_i = 1'b0; adv_i = 1'b1;
        edge_then_settle();
        adv_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            edge_then_settle();
            chk("R7 hold", int'(addr_o), 2);
        end

        // R8 standby ignores advance and load
        sleep_i = 1'b1; adv_i = 1'b1;
        edge_then_settle();
        chk("R8 adv ignored", int'(addr_o), 2);
        load_i = 1'b1; start_i = 2'd3; adv_i = 1'b0;
        #1;
        chk("R8 load bypass blocked", int'(addr_o), 2);
        edge_then_settle();
        chk("R8 load ignored", int'(addr_o), 2);
        chk("R8 last", int'(last_o), 0);
        load_i = 1'b0; sleep_i = 1'b0; adv_i = 1'b1;
        edge_then_settle();
        chk("R8 resume", int'(addr_o), 3);

        // R9 load outranks advance, interleaved order
        ilv_i = 1'b1;
        load_i = 1'b1; start_i = 2'd2; adv_i = 1'b1;
        edge_then_settle();
        load_i = 1'b0; adv_i = 1'b0;
        chk("R9 beat0", int'(addr_o), 2);
        chk("R9 last", int'(last_o), 0);

        // R1 reset mid-burst
        adv_i = 1'b1;
        edge_then_settle();
        rst_n = 1'b0; adv_i = 1'b0;
        edge_then_settle();
        rst_n = 1'b1;
        #1;
        chk("R1 mid reset", int'(addr_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule